// File: doc/BRIEF.md
# Paper-Tape Absolute Loader Parser

This block turns a byte stream in absolute-loader block format into byte writes to a word-organised memory. It takes at most one byte per clock, marked by a valid strobe. It skips leader bytes and decodes each block header. It sends every data byte straight to the memory write port in the same cycle the byte arrives, and it checks the block checksum. A block that carries a byte count of six ends the load. Such a block may also supply a program start address.

The surrounding logic feeds the bytes from a tape reader. It gives a one-cycle end indication when the stream runs out, and it watches the flags: done, checksum error, address out of range and premature end. A start pulse or a synchronous reset prepares the parser for a new tape. After completion or after any error, every further byte is ignored until that happens.

Top module: `tape_block_loader`

## Requirements
- R1: Before a block begins, each byte other than 0x01 is thrown away, produces no memory write and zeroes the running sum. A byte of 0x01 opens a block.
- R2: After the 0x01, one byte is skipped but still added to the sum. Then come four header bytes: the length (low byte, then high byte) and the load origin (low byte, then high byte). Both values are 16 bits, little-endian, and the length counts the six header bytes.
- R3: A data byte is written in the same cycle as its strobe. The write goes to word address origin>>1 with exactly one byte enable. An even origin uses memBe=01 with the byte on memData[7:0]. An odd origin uses memBe=10 with the byte on memData[15:8].
- R4: A block of length N carries N-6 data bytes, and the origin steps up by one after each of them.
- R5: One checksum byte follows the data. If the 8-bit sum of all bytes from the 0x01 through the checksum is not zero, csumErr is set and parsing stops.
- R6: After a correct checksum, the parser goes back to leader search with the sum cleared, so the next block parses normally.
- R7: A block whose length is exactly 6 carries no data and no checksum. done rises at the clock edge that takes its origin high byte.
- R8: On the final block, an origin other than 0x0001 sets startValid, and startAddr is that origin with bit 0 cleared. An origin of 0x0001 leaves startValid low.
- R9: A data byte whose byte address is at or above 2*MEM_WORDS is not written. It sets rangeErr and stops parsing.
- R10: An end indication before done sets eofErr. An end indication after done changes nothing.
- R11: The flags are sticky. Once done or any error flag is set, no byte causes a write or changes a flag. A start pulse clears all flags and startValid and restarts leader search.
- R12: After reset, done, every error flag, startValid and memWe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Clears flags and restarts parsing |
| inByte | input | 8 | Tape byte |
| inValid | input | 1 | inByte is valid this cycle |
| inEnd | input | 1 | The byte stream has ended |
| memWe | output | 1 | Memory write strobe |
| memAddr | output | ADDR_W | Word address of the write |
| memData | output | 16 | Write data, byte copied into both lanes |
| memBe | output | 2 | Byte-lane enables |
| startAddr | output | 16 | Program start address |
| startValid | output | 1 | startAddr is meaningful |
| done | output | 1 | Load complete |
| csumErr | output | 1 | Block checksum mismatch |
| rangeErr | output | 1 | Data address beyond memory |
| eofErr | output | 1 | Stream ended before the final block |

## Verification
The assertions rely on rst being held high from time zero until the first clock edges have passed. They also rely on start and rst never arriving in the same cycle as a byte whose effect the assertions follow. The bench drives bytes only between clock edges, removes the strobe after each edge, and pulses start only while no byte is offered. The assertions assume that a byte and the end indication never arrive together. The stimulus always raises inEnd in a cycle of its own.

// File: rtl/tbl_pkg.sv
package tbl_pkg;
  localparam logic [7:0]  MARK_BYTE      = 8'h01;
  localparam logic [15:0] FINAL_LENGTH   = 16'd6;
  localparam logic [15:0] HEADER_BYTES   = 16'd6;
  localparam logic [15:0] NO_START_ORIGIN = 16'h0001;
  localparam int          LANES          = 2;

  typedef enum logic [3:0] {
    ST_LEADER,
    ST_SKIP,
    ST_LEN_LO,
    ST_LEN_HI,
    ST_ORG_LO,
    ST_ORG_HI,
    ST_DATA,
    ST_CSUM,
    ST_HALT
  } parseState_t;

  typedef struct packed {
    logic sumClr;
    logic sumLoad;
    logic sumAdd;
    logic ldLenLo;
    logic ldLenHi;
    logic ldOrgLo;
    logic ldOrgHi;
    logic ldStart;
    logic wrData;
  } dpCtl_t;

  typedef struct packed {
    logic lenIsFinal;
    logic orgIsNoStart;
    logic remIsOne;
    logic addrOutOfRange;
    logic sumWillZero;
  } dpStat_t;
endpackage

// File: rtl/tbl_dpath.sv
module tbl_dpath
  import tbl_pkg::*;
#(
  parameter int MEM_WORDS = 4096,
  parameter int ADDR_W    = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [7:0]        inByte,
  input  dpCtl_t            ctl,
  output dpStat_t           stat,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [15:0]       memData,
  output logic [LANES-1:0]  memBe,
  output logic [15:0]       startAddr
);
  localparam logic [16:0] MEM_BYTES = 17'(2 * MEM_WORDS);

  logic [7:0]  sumReg;
  logic [15:0] lenReg;
  logic [15:0] orgReg;
  logic [15:0] remReg;
  logic [15:0] startReg;
  logic [7:0]  sumPlus;
  logic        clr;

  assign clr     = rst | start;
  assign sumPlus = sumReg + inByte;

  always_ff @(posedge clk) begin
    if (clr) begin
      sumReg   <= '0;
      lenReg   <= '0;
      orgReg   <= '0;
      remReg   <= '0;
      startReg <= '0;
    end else begin
      if (ctl.sumClr)       sumReg <= '0;
      else if (ctl.sumLoad) sumReg <= inByte;
      else if (ctl.sumAdd)  sumReg <= sumPlus;

      if (ctl.ldLenLo) lenReg[7:0]  <= inByte;
      if (ctl.ldLenHi) lenReg[15:8] <= inByte;
      if (ctl.ldOrgLo) orgReg[7:0]  <= inByte;

      if (ctl.ldOrgHi) begin
        orgReg[15:8] <= inByte;
        remReg       <= lenReg - HEADER_BYTES;
      end else if (ctl.wrData) begin
        orgReg <= orgReg + 16'd1;
        remReg <= remReg - 16'd1;
      end

      if (ctl.ldStart) startReg <= {inByte, orgReg[7:1], 1'b0};
    end
  end

  assign stat.lenIsFinal     = (lenReg == FINAL_LENGTH);
  assign stat.orgIsNoStart   = ({inByte, orgReg[7:0]} == NO_START_ORIGIN);
  assign stat.remIsOne       = (remReg == 16'd1);
  assign stat.addrOutOfRange = ({1'b0, orgReg} >= MEM_BYTES);
  assign stat.sumWillZero    = (sumPlus == 8'h00);

  assign memWe     = ctl.wrData;
  assign memAddr   = orgReg[ADDR_W:1];
  assign startAddr = startReg;

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    assign memBe[lane]           = (orgReg[0] == 1'(lane));
    assign memData[lane*8 +: 8]  = inByte;
  end

  AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    memWe |-> !stat.addrOutOfRange); // R9
  AST_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
    memWe |-> ($countones(memBe) == 1)); // R3
endmodule

// File: rtl/tbl_ctrl.sv
module tbl_ctrl
  import tbl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] inByte,
  input  logic       inValid,
  input  logic       inEnd,
  input  dpStat_t    stat,
  output dpCtl_t     ctl,
  output logic       done,
  output logic       csumErr,
  output logic       rangeErr,
  output logic       eofErr,
  output logic       startValid
);
  parseState_t state, nextState;
  logic accept;
  logic setDone, setCsum, setRange, setEof, setStart;

  assign accept = inValid && (state != ST_HALT);

  always_comb begin
    ctl       = '0;
    nextState = state;
    setDone   = 1'b0;
    setCsum   = 1'b0;
    setRange  = 1'b0;
    setStart  = 1'b0;
    if (accept) begin
      unique case (state)
        ST_LEADER: begin
          if (inByte == MARK_BYTE) begin
            ctl.sumLoad = 1'b1;
            nextState   = ST_SKIP;
          end else begin
            ctl.sumClr = 1'b1;
          end
        end
        ST_SKIP: begin
          ctl.sumAdd = 1'b1;
          nextState  = ST_LEN_LO;
        end
        ST_LEN_LO: begin
          ctl.sumAdd  = 1'b1;
          ctl.ldLenLo = 1'b1;
          nextState   = ST_LEN_HI;
        end
        ST_LEN_HI: begin
          ctl.sumAdd  = 1'b1;
          ctl.ldLenHi = 1'b1;
          nextState   = ST_ORG_LO;
        end
        ST_ORG_LO: begin
          ctl.sumAdd  = 1'b1;
          ctl.ldOrgLo = 1'b1;
          nextState   = ST_ORG_HI;
        end
        ST_ORG_HI: begin
          ctl.sumAdd  = 1'b1;
          ctl.ldOrgHi = 1'b1;
          if (stat.lenIsFinal) begin
            setDone   = 1'b1;
            nextState = ST_HALT;
            if (!stat.orgIsNoStart) begin
              ctl.ldStart = 1'b1;
              setStart    = 1'b1;
            end
          end else begin
            nextState = ST_DATA;
          end
        end
        ST_DATA: begin
          if (stat.addrOutOfRange) begin
            setRange  = 1'b1;
            nextState = ST_HALT;
          end else begin
            ctl.sumAdd = 1'b1;
            ctl.wrData = 1'b1;
            if (stat.remIsOne) nextState = ST_CSUM;
          end
        end
        ST_CSUM: begin
          if (stat.sumWillZero) begin
            ctl.sumClr = 1'b1;
            nextState  = ST_LEADER;
          end else begin
            setCsum   = 1'b1;
            nextState = ST_HALT;
          end
        end
        default: nextState = ST_HALT;
      endcase
    end
  end

  assign setEof = inEnd && (state != ST_HALT) && (nextState != ST_HALT);

  always_ff @(posedge clk) begin
    if (rst || start) begin
      state      <= ST_LEADER;
      done       <= 1'b0;
      csumErr    <= 1'b0;
      rangeErr   <= 1'b0;
      eofErr     <= 1'b0;
      startValid <= 1'b0;
    end else begin
      state      <= setEof ? ST_HALT : nextState;
      done       <= done | setDone;
      csumErr    <= csumErr | setCsum;
      rangeErr   <= rangeErr | setRange;
      eofErr     <= eofErr | setEof;
      startValid <= startValid | setStart;
    end
  end

  AST_HALT_SILENT: assert property (@(posedge clk) disable iff (rst)
    (done || csumErr || rangeErr || eofErr) |-> !ctl.wrData); // R11
  AST_CSUM_STICKY: assert property (@(posedge clk) disable iff (rst)
    (csumErr && !start) |=> csumErr); // R11
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done); // R11
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    $countones({done, csumErr, rangeErr, eofErr}) <= 1); // R11
  AST_EOF_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> !eofErr); // R10
endmodule

// File: rtl/tape_block_loader.sv
module tape_block_loader
  import tbl_pkg::*;
#(
  parameter int MEM_WORDS = 4096,
  parameter int ADDR_W    = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [7:0]        inByte,
  input  logic              inValid,
  input  logic              inEnd,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [15:0]       memData,
  output logic [1:0]        memBe,
  output logic [15:0]       startAddr,
  output logic              startValid,
  output logic              done,
  output logic              csumErr,
  output logic              rangeErr,
  output logic              eofErr
);
  dpCtl_t  ctl;
  dpStat_t stat;

  tbl_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .inByte     (inByte),
    .inValid    (inValid),
    .inEnd      (inEnd),
    .stat       (stat),
    .ctl        (ctl),
    .done       (done),
    .csumErr    (csumErr),
    .rangeErr   (rangeErr),
    .eofErr     (eofErr),
    .startValid (startValid)
  );

  tbl_dpath #(
    .MEM_WORDS (MEM_WORDS),
    .ADDR_W    (ADDR_W)
  ) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .inByte    (inByte),
    .ctl       (ctl),
    .stat      (stat),
    .memWe     (memWe),
    .memAddr   (memAddr),
    .memData   (memData),
    .memBe     (memBe),
    .startAddr (startAddr)
  );

  AST_WE_NEEDS_BYTE: assert property (@(posedge clk) disable iff (rst)
    memWe |-> inValid); // R3
  AST_START_EVEN: assert property (@(posedge clk) disable iff (rst)
    startValid |-> !startAddr[0]); // R8
  AST_START_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    startValid |-> done); // R8
endmodule

// File: tb/tb_tape_block_loader.sv
`timescale 1ns/1ps
module tb_tape_block_loader;
  localparam int MEM_WORDS = 4096;
  localparam int ADDR_W    = $clog2(MEM_WORDS);
  localparam int TAPE_LEN  = 32;

  // entry: {byte, expect write, expect lanes, expect word address}
  localparam logic [26:0] TAPE [TAPE_LEN] = '{
    {8'h00, 1'b0, 2'b00, 16'h0000},
    {8'h00, 1'b0, 2'b00, 16'h0000},
    {8'h05, 1'b0, 2'b00, 16'h0000},
    {8'h01, 1'b0, 2'b00, 16'h0000},
    {8'h00, 1'b0, 2'b00, 16'h0000},
    {8'h09, 1'b0, 2'b00, 16'h0000},
    {8'h00, 1'b0, 2'b00, 16'h0000},
    {8'h01, 1'b0, 2'b00, 16'h0000},
    {8'h01, 1'b0, 2'b00, 16'h0000},
    {8'hAA, 1'b1, 2'b10, 16'h0080},
    {8'hBB, 1'b1, 2'b01, 16'h0081},
    {8'hCC, 1'b1, 2'b10, 16'h0081},
    {8'hC3, 1'b0, 2'b00, 16'h0000},
    {8'h37, 1'b0, 2'b00, 16'h0000},
    {8'h01, 1'b0, 2'b00, 16'h0000},
    {8'h7F, 1'b0, 2'b00, 16'h0000},
    {8'h08, 1'b0, 2'b00, 16'h0000},
    {8'h00, 1'b0, 2'b00, 16'h0000},
    {8'h10, 1'b0, 2'b00, 16'h0000},
    {8'h00, 1'b0, 2'b00, 16'h0000},
    {8'h11, 1'b1, 2'b01, 16'h0008},
    {8'h22, 1'b1, 2'b10, 16'h0008},
    {8'h35, 1'b0, 2'b00, 16'h0000},
    {8'h00, 1'b0, 2'b00, 16'h0000},
    {8'h00, 1'b0, 2'b00, 16'h0000},
    {8'h00, 1'b0, 2'b00, 16'h0000},
    {8'h01, 1'b0, 2'b00, 16'h0000},
    {8'h00, 1'b0, 2'b00, 16'h0000},
    {8'h06, 1'b0, 2'b00, 16'h0000},
    {8'h00, 1'b0, 2'b00, 16'h0000},
    {8'h01, 1'b0, 2'b00, 16'h0000},
    {8'h02, 1'b0, 2'b00, 16'h0000}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [7:0]        inByte = '0;
  logic              inValid = 1'b0;
  logic              inEnd = 1'b0;
  logic              memWe;
  logic [ADDR_W-1:0] memAddr;
  logic [15:0]       memData;
  logic [1:0]        memBe;
  logic [15:0]       startAddr;
  logic              startValid, done, csumErr, rangeErr, eofErr;

  int nChecks = 0;
  int nFail   = 0;
  logic              sWe;
  logic [1:0]        sBe;
  logic [ADDR_W-1:0] sAddr;
  logic [15:0]       sData;

  always #4 clk = ~clk;

  tape_block_loader #(.MEM_WORDS(MEM_WORDS)) dut (
    .clk(clk), .rst(rst), .start(start), .inByte(inByte), .inValid(inValid),
    .inEnd(inEnd), .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .memBe(memBe), .startAddr(startAddr), .startValid(startValid),
    .done(done), .csumErr(csumErr), .rangeErr(rangeErr), .eofErr(eofErr)
  );

  task automatic checkVal(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    inByte  = b;
    inValid = 1'b1;
    #2;
    sWe   = memWe;
    sBe   = memBe;
    sAddr = memAddr;
    sData = memData;
    @(posedge clk);
    #1;
    inValid = 1'b0;
  endtask

  task automatic pulseStart();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic endStream();
    @(negedge clk);
    inEnd = 1'b1;
    @(negedge clk);
    inEnd = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    checkVal("R12 done", done, 0);
    checkVal("R12 errs", {csumErr, rangeErr, eofErr}, 0);
    checkVal("R12 startValid", startValid, 0);
    checkVal("R12 memWe", memWe, 0);

    // table walk: R1 R2 R3 R4 R6 R7
    for (int i = 0; i < TAPE_LEN; i++) begin
      sendByte(TAPE[i][26:19]);
      checkVal("R1/R3 write strobe", sWe, TAPE[i][18]);
      if (TAPE[i][18]) begin
        checkVal("R3 lanes", sBe, TAPE[i][17:16]);
        checkVal("R4 word address", 32'(sAddr), 32'(TAPE[i][15:0]));
        if (TAPE[i][17:16] == 2'b01) checkVal("R3 low lane data", sData[7:0], TAPE[i][26:19]);
        else                         checkVal("R3 high lane data", sData[15:8], TAPE[i][26:19]);
      end
    end
    checkVal("R7 done", done, 1);
    checkVal("R6 no csum error", csumErr, 0);
    checkVal("R8 startValid", startValid, 1);
    checkVal("R8 startAddr", startAddr, 16'h0200);
    endStream();
    checkVal("R10 end after done", eofErr, 0);

    // R5 bad checksum then R11 halt
    pulseStart();
    checkVal("R11 start clears done", done, 0);
    sendByte(8'h01); sendByte(8'h00); sendByte(8'h07); sendByte(8'h00);
    sendByte(8'h00); sendByte(8'h00);
    sendByte(8'h44);
    checkVal("R3 write at word 0", {sWe, sBe, 16'(sAddr)}, {1'b1, 2'b01, 16'h0000});
    sendByte(8'hB5);
    checkVal("R5 csumErr", csumErr, 1);
    begin
      logic [7:0] fin [6] = '{8'h01, 8'h00, 8'h06, 8'h00, 8'h01, 8'h02};
      for (int k = 0; k < 6; k++) begin
        sendByte(fin[k]);
        checkVal("R11 no write after error", sWe, 0);
      end
    end
    checkVal("R11 done held low", done, 0);
    checkVal("R11 csumErr sticky", csumErr, 1);
    checkVal("R11 startValid held", startValid, 0);

    // R11 start clears; R8 origin of one
    pulseStart();
    checkVal("R11 flags cleared", {done, csumErr, rangeErr, eofErr, startValid}, 0);
    sendByte(8'h01); sendByte(8'h00); sendByte(8'h06); sendByte(8'h00);
    sendByte(8'h01);
    checkVal("R7 not done before origin high", done, 0);
    sendByte(8'h00);
    checkVal("R7 done origin one", done, 1);
    checkVal("R8 no start address", startValid, 0);

    // R9 range error at top of memory
    pulseStart();
    sendByte(8'h01); sendByte(8'h00); sendByte(8'h08); sendByte(8'h00);
    sendByte(8'hFF); sendByte(8'h1F);
    sendByte(8'h5A);
    checkVal("R9 last byte written", {sWe, sBe, 16'(sAddr)}, {1'b1, 2'b10, 16'h0FFF});
    checkVal("R9 last byte data", sData[15:8], 8'h5A);
    sendByte(8'h6B);
    checkVal("R9 beyond memory no write", sWe, 0);
    checkVal("R9 rangeErr", rangeErr, 1);
    checkVal("R9 not done", done, 0);

    // R10 premature end
    pulseStart();
    sendByte(8'h01); sendByte(8'h00); sendByte(8'h08);
    endStream();
    checkVal("R10 eofErr", eofErr, 1);
    checkVal("R10 not done", done, 0);
    sendByte(8'h00);
    checkVal("R11 no write after end", sWe, 0);

    // R12 synchronous reset clears
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    checkVal("R12 reset clears eofErr", eofErr, 0);

    summary();
    $finish;
  end
endmodule